// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Flags

This block holds two 8-bit interval timers that share one interrupt status byte. A host programs it through a single write port with an address and a data byte. Two addresses hold the timer presets and a third holds the control byte. Each timer counts up from its preset once per prescaled tick. When it passes its top value it reloads the preset and raises its own status flag, unless software has masked that flag.

Both timers share one free-running prescaler built from the master clock. Timer A ticks every `TICK_DIV` clocks. Timer B ticks `B_RATIO` times more slowly. The `irq` output is the OR of the two flags, and bit 7 of the always-visible `status` byte mirrors it. The control byte starts and stops each timer and masks each flag. Writing it with bit 7 set clears both flags and leaves the control settings alone.

Top module: `dual_interval_timer`

## Requirements
- R1: A synchronous reset sets `status` to 0x00 and `irq` to 0, clears both presets and the control byte, and so stops both timers. A preset of 0 gives a period of 256 ticks.
- R2: Timer A ticks every `TICK_DIV` clocks. While it runs, its overflows are (256 − preset) × `TICK_DIV` clocks apart, and each overflow sets status bit 6.
- R3: Timer B ticks every `TICK_DIV` × `B_RATIO` clocks. While it runs, its overflows are (256 − preset) × `TICK_DIV` × `B_RATIO` clocks apart, and each overflow sets status bit 5.
- R4: Control bit 0 runs timer A and control bit 1 runs timer B. Any change of a run bit reloads that timer from its preset. After a start, the first overflow comes more than (N−1)·T and at most N·T clocks after the write edge, where N = 256 − preset and T is that timer's tick period. A stopped timer never overflows.
- R5: Control bit 6 masks flag A and control bit 5 masks flag B. A masked timer keeps counting in the same phase. After unmasking, its next overflow sets the flag again.
- R6: A write to the control byte (address 0x04) with bit 7 set clears both flags and leaves the run and mask bits unchanged.
- R7: A control write with bit 7 clear stores bits 6..0 as the new control byte. It also clears each flag whose bit position (6 or 5) is 1 in the data.
- R8: `irq` is the OR of the two flags. `status` carries `irq` in bit 7, flag A in bit 6 and flag B in bit 5, with bits 4..0 at zero.
- R9: If an overflow and a clear-all write land in the same cycle, the flag ends up set. If an overflow and a control write with bit 7 clear land in the same cycle, the newly written mask bit decides whether the flag is set.
- R10: A preset write (address 0x02 for A, 0x03 for B) leaves the period already in progress untouched. The new value takes effect at the next reload.
- R11: A write to any address other than 0x02, 0x03 or 0x04 changes neither the flags, nor the presets, nor the timer phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Write data |
| status | output | 8 | Registered status: bit 7 interrupt, bit 6 flag A, bit 5 flag B |
| irq | output | 1 | Registered interrupt request, OR of the flags |

## Verification
The case most likely to go wrong is an overflow landing in the same cycle as a control write that clears flags. The bench first measures one full period of timer A. It then times a write so that it is sampled on exactly the edge of the next predicted overflow. After a clear-all write on that edge, the flag must read as set. After a write of a new mask on that edge, the flag must stay clear and `irq` must stay low.

// File: rtl/dtim_pkg.sv
package dtim_pkg;
  localparam int          NUM_TMR         = 2;
  localparam int          DATA_W          = 8;
  localparam logic [7:0]  ADDR_PRESET_A   = 8'h02;
  localparam logic [7:0]  ADDR_CTRL       = 8'h04;
  localparam int          CLR_ALL_BIT     = 7;
  localparam int          IRQ_BIT         = 7;
  // flag / mask position of timer i is FLAG_TOP - i (A at 6, B at 5)
  localparam int          FLAG_TOP        = 6;
endpackage

// File: rtl/dtim_prescaler.sv
module dtim_prescaler #(
  parameter int TICK_DIV = 2736,
  parameter int B_RATIO  = 4
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] tick
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int BW = (B_RATIO > 1) ? $clog2(B_RATIO) : 1;
  localparam logic [PW-1:0] P_LAST = PW'(TICK_DIV - 1);
  localparam logic [BW-1:0] B_LAST = BW'(B_RATIO - 1);

  logic [PW-1:0] pcnt_q;
  logic [BW-1:0] bcnt_q;
  logic          a_wrap;

  assign a_wrap  = (pcnt_q == P_LAST);
  assign tick[0] = a_wrap;
  assign tick[1] = a_wrap && (bcnt_q == B_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      pcnt_q <= a_wrap ? '0 : pcnt_q + 1'b1;
      if (a_wrap)
        bcnt_q <= (bcnt_q == B_LAST) ? '0 : bcnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/dtim_counter.sv
module dtim_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] preset,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             at_top;

  assign at_top = (cnt_q == TOP);
  // a restart in the same cycle swallows the wrap
  assign ovf    = run && tick && at_top && !restart;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (restart)
      cnt_q <= preset;
    else if (run && tick)
      cnt_q <= at_top ? preset : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dtim_flags.sv
module dtim_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] ovf,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] flags_nx;

  // a fresh overflow beats a clear in the same cycle
  assign flags_nx = (flags & ~clr) | (ovf & ~mask);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= flags_nx;
      irq   <= |flags_nx;
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
module dual_interval_timer
  import dtim_pkg::*;
#(
  parameter int TICK_DIV = 2736,
  parameter int B_RATIO  = 4,
  parameter int CNT_W    = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  output logic [7:0]  status,
  output logic        irq
);
  logic [CNT_W-1:0]   preset_q [NUM_TMR];
  logic [7:0]         ctrl_q, ctrl_nx;
  logic               ctrl_wr, clr_all;
  logic [NUM_TMR-1:0] tick, restart, ovf, mask_eff, clr_sel, flags_q;

  always_comb begin
    ctrl_wr = wr_en && (wr_addr == ADDR_CTRL);
    clr_all = ctrl_wr && wr_data[CLR_ALL_BIT];
    ctrl_nx = ctrl_q;
    if (ctrl_wr && !wr_data[CLR_ALL_BIT])
      ctrl_nx = {1'b0, wr_data[6:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else     ctrl_q <= ctrl_nx;
  end

  dtim_prescaler #(.TICK_DIV(TICK_DIV), .B_RATIO(B_RATIO)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    localparam logic [7:0] PADDR = ADDR_PRESET_A + 8'(i);
    localparam int         FB    = FLAG_TOP - i;

    always_ff @(posedge clk) begin
      if (rst)
        preset_q[i] <= '0;
      else if (wr_en && (wr_addr == PADDR))
        preset_q[i] <= wr_data[CNT_W-1:0];
    end

    assign restart[i]  = ctrl_nx[i] ^ ctrl_q[i];
    assign mask_eff[i] = ctrl_nx[FB];
    assign clr_sel[i]  = clr_all || (ctrl_wr && !wr_data[CLR_ALL_BIT] && wr_data[FB]);

    dtim_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk     (clk),
      .rst     (rst),
      .run     (ctrl_q[i]),
      .tick    (tick[i]),
      .restart (restart[i]),
      .preset  (preset_q[i]),
      .ovf     (ovf[i])
    );
  end

  dtim_flags #(.N(NUM_TMR)) u_flg (
    .clk   (clk),
    .rst   (rst),
    .ovf   (ovf),
    .mask  (mask_eff),
    .clr   (clr_sel),
    .flags (flags_q),
    .irq   (irq)
  );

  always_comb begin
    status          = '0;
    status[IRQ_BIT] = irq;
    for (int i = 0; i < NUM_TMR; i++)
      status[FLAG_TOP-i] = flags_q[i];
  end
endmodule

// File: rtl/dtim_chk.sv
module dtim_chk
  import dtim_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic [7:0] wr_data,
  input logic [7:0] status,
  input logic       irq,
  input logic [7:0] ctrl_q,
  input logic [1:0] ovf
);
  logic ctrl_hit;
  assign ctrl_hit = wr_en && (wr_addr == ADDR_CTRL);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (status == 8'h00 && !irq));

  // R8
  irq_flags_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (status[6] | status[5]));

  // R6
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && wr_data[7]) |=> $stable(ctrl_q));

  // R7
  named_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl_hit && !wr_data[7] && wr_data[6]) |=> !status[6]);

  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_hit && ctrl_q[6] && !status[6]) |=> !status[6]);

  // R2
  flag_source_chk: assert property (@(posedge clk) disable iff (rst)
    (!status[6] && !ovf[0]) |=> !status[6]);
endmodule

bind dual_interval_timer dtim_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .status  (status),
  .irq     (irq),
  .ctrl_q  (ctrl_q),
  .ovf     (ovf)
);

// File: tb/tb_dual_interval_timer.sv
module tb_dual_interval_timer;
  localparam int CLK_PERIOD = 10;
  localparam int D          = 4;
  localparam int BR         = 4;
  localparam int WD_CYCLES  = 150000;
  localparam logic [7:0] A_PRE = 8'h02;
  localparam logic [7:0] B_PRE = 8'h03;
  localparam logic [7:0] CTRL  = 8'h04;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] status;
  logic       irq;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  dual_interval_timer #(.TICK_DIV(D), .B_RATIO(BR), .CNT_W(8)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .status(status), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // called at a negedge; the write is taken at the next posedge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_flag(input int bitn, input int limit, output int t);
    t = -1;
    for (int k = 0; k < limit; k++) begin
      if (status[bitn]) begin
        t = cyc;
        break;
      end
      @(negedge clk);
    end
  endtask

  // R2 R3 R4 R8: start timer idx with preset p, check first window and period
  task automatic measure(input int idx, input int p);
    int n, tp, s, t0, t1, fb;
    logic [7:0] expst;
    n  = 256 - p;
    tp = (idx == 0) ? D : D * BR;
    fb = 6 - idx;
    expst = (idx == 0) ? 8'hC0 : 8'hA0;
    wr(CTRL, 8'h00);
    wr(CTRL, 8'h80);
    wr((idx == 0) ? A_PRE : B_PRE, 8'(p));
    wr(CTRL, (idx == 0) ? 8'h01 : 8'h02);
    s = cyc;
    wait_flag(fb, n * tp + 8, t0);
    chk(t0 > s + (n - 1) * tp && t0 <= s + n * tp, "R4 first overflow window", t0 - s, n * tp);
    chk(status == expst, "R8 status layout", int'(status), int'(expst));
    wr(CTRL, 8'h80);
    wait_flag(fb, n * tp + 8, t1);
    chk(t0 >= 0 && t1 - t0 == n * tp, (idx == 0) ? "R2 period A" : "R3 period B", t1 - t0, n * tp);
  endtask

  initial begin : wd
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int s, t0, t1, t2, t3, tf, tb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(status == 8'h00 && irq == 1'b0, "R1 reset status", int'(status), 0);

    // R1: default preset 0 -> 256 ticks
    wr(CTRL, 8'h01);
    s = cyc;
    wait_flag(6, 256 * D + 8, t0);
    chk(t0 > s + 255 * D && t0 <= s + 256 * D, "R1 default preset window", t0 - s, 256 * D);
    wr(CTRL, 8'h80);
    wait_flag(6, 256 * D + 8, t1);
    chk(t1 - t0 == 256 * D, "R1 default preset period", t1 - t0, 256 * D);

    // R2 sweep and R3 sweep
    for (int p = 192; p < 256; p++) measure(0, p);
    for (int p = 224; p < 256; p++) measure(1, p);

    // R4 stopped timers never overflow
    wr(CTRL, 8'h00);
    wr(CTRL, 8'h80);
    repeat (100) @(negedge clk);
    chk(status == 8'h00 && !irq, "R4 stopped timers silent", int'(status), 0);

    // R9 same-cycle overflow and clear-all
    wr(A_PRE, 8'd250);
    wr(CTRL, 8'h01);
    wait_flag(6, 200, t0);
    wr(CTRL, 8'h80);
    repeat (24 - 2) @(negedge clk);
    wr(CTRL, 8'h80);
    chk(status[6] == 1'b1 && irq, "R9 overflow beats clear-all", int'(status), 8'hC0);
    wr(CTRL, 8'h80);
    wait_flag(6, 200, t2);
    // R6 run bit untouched by clear-all
    chk(t2 - t0 == 48, "R6 control kept across clear-all", t2 - t0, 48);

    // R9 same-cycle overflow and new mask
    wr(CTRL, 8'h80);
    repeat (24 - 2) @(negedge clk);
    wr(CTRL, 8'h41);
    chk(status == 8'h00 && !irq, "R9 new mask blocks same-cycle overflow", int'(status), 0);
    repeat (72) @(negedge clk);
    chk(status == 8'h00, "R5 masked flag stays clear", int'(status), 0);
    wr(CTRL, 8'h01);
    wait_flag(6, 200, tf);
    chk(tf > t2 && (tf - t2) % 24 == 0, "R5 masked timer keeps phase", (tf - t2) % 24, 0);

    // R7 named clear while both flags are set
    wr(B_PRE, 8'd254);
    wr(CTRL, 8'h03);
    wait_flag(5, 100, tb);
    chk(tb >= 0 && status == 8'hE0, "R8 both flags", int'(status), 8'hE0);
    wr(CTRL, 8'h23);
    chk(status == 8'hC0 && irq, "R7 named clear of B only", int'(status), 8'hC0);
    wr(CTRL, 8'h63);
    chk(status == 8'h00 && !irq, "R7 named clear of A", int'(status), 0);

    // R10 preset change mid-period
    wr(CTRL, 8'h00);
    wr(CTRL, 8'h80);
    wr(A_PRE, 8'd250);
    wr(CTRL, 8'h01);
    wait_flag(6, 200, t0);
    wr(A_PRE, 8'd252);
    wr(CTRL, 8'h80);
    wait_flag(6, 200, t1);
    chk(t1 - t0 == 24, "R10 in-flight period kept", t1 - t0, 24);
    wr(CTRL, 8'h80);
    wait_flag(6, 200, t2);
    chk(t2 - t1 == 16, "R10 new preset at reload", t2 - t1, 16);

    // R11 writes elsewhere are ignored
    wr(8'h05, 8'hFF);
    chk(status == 8'hC0, "R11 stray write keeps flags", int'(status), 8'hC0);
    wr(8'h00, 8'h00);
    wr(CTRL, 8'h80);
    wait_flag(6, 200, t3);
    chk(t3 - t2 == 16, "R11 stray writes keep preset and phase", t3 - t2, 16);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule